// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small processor core that retires one instruction on every clock edge. The instruction and data memories are separate and both live inside the core. In each cycle the core reads a 32-bit word from instruction memory at the program counter and pulls every field out of that word in parallel. It decodes the opcode and function code into a handful of select lines. It reads two registers without waiting for a clock, then runs the ALU. Depending on the instruction, it then reads or writes one data word, and it commits both the register result and the next program counter on the following rising edge.

Program and data are placed into the two memories through a simple word-wide load port while the core is held in reset. Once reset is released, the core runs on its own. The current program counter, the fetched word, the register write about to commit and the store about to commit are all visible on output ports, so the surrounding logic can follow execution one instruction at a time. The supported instructions are add, sub, and, or, slt, addi, lw, sw, beq and j.

Top module: `scp_core`

## Requirements
- R1: While rst_n is low, pc reads 0 and neither wb_en nor st_en is asserted. After reset is released, every register reads 0 until it is first written.
- R2: An R-type word has opcode 000000 in bits [31:26], rs in [25:21], rt in [20:16] and rd in [15:11]. With function code 0x20 in bits [5:0], the core writes rs+rt into rd. For example, add $3,$1,$2 is the word 0x00221820.
- R3: R-type function codes 0x22, 0x24, 0x25 and 0x2A write rs−rt, rs AND rt, rs OR rt, and a signed rs<rt test (1 or 0) into rd.
- R4: Opcode 0x08 (addi) writes rs plus the sign-extended bits [15:0] into rt.
- R5: Register 0 always reads as 0. An instruction whose destination is register 0 commits nothing, and wb_en stays low.
- R6: Opcode 0x23 (lw) writes into rt the data word at byte address rs+sext(imm16). The two lowest address bits are ignored when selecting the word.
- R7: Opcode 0x2B (sw) stores rt at byte address rs+sext(imm16). The word commits on the next edge, and the instruction writes no register.
- R8: Opcode 0x04 (beq) moves pc to pc+4+(sext(imm16)<<2) when rs equals rt. Otherwise it moves pc to pc+4.
- R9: Opcode 0x02 (j) moves pc to {upper four bits of pc+4, bits [25:0], 00}.
- R10: Every other instruction advances pc by 4, so pc is always word aligned.
- R11: Any other opcode, and any R-type function code not listed in R2 and R3, writes no register, stores nothing, and advances pc by 4.
- R12: From reset, addi $1,$0,5; addi $2,$0,10; add $3,$1,$2 commit 5, 10 and 15 into registers 1, 2 and 3, and pc reads 0x0C after three edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset for pc and registers |
| ld_we | input | 1 | Load-port write strobe, used while in reset |
| ld_dmem | input | 1 | Load-port target: 1 selects data memory, 0 selects instruction memory |
| ld_addr | input | 32 | Load-port byte address (low two bits ignored) |
| ld_data | input | 32 | Load-port word |
| pc | output | 32 | Current program counter |
| instr | output | 32 | Instruction word fetched at pc |
| wb_en | output | 1 | A register write commits at the next edge |
| wb_addr | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value of that write |
| st_en | output | 1 | A data-memory store commits at the next edge |
| st_addr | output | 32 | Byte address of that store |
| st_data | output | 32 | Word of that store |

## Verification
The fetched word, the register write and the store are combinational on the current pc and register state, so they are due in the same cycle the instruction is fetched. The register contents, the stored word and the new pc appear one rising edge later. The bench keeps a behavioural model of the registers, memories and pc, and compares every output half a clock after each edge, when the current instruction's results have settled. It advances the model exactly once per edge. A value written in one cycle is therefore first seen as an operand, a loaded word or a pc in the next cycle's comparison.

// File: rtl/scp_core.sv
module scp_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREGS      = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_we,
  input  logic        ld_dmem,
  input  logic [31:0] ld_addr,
  input  logic [31:0] ld_data,
  output logic [31:0] pc,
  output logic [31:0] instr,
  output logic        wb_en,
  output logic [4:0]  wb_addr,
  output logic [31:0] wb_data,
  output logic        st_en,
  output logic [31:0] st_addr,
  output logic [31:0] st_data
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_t;

  logic [31:0] pc_q;
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] regs [NREGS];

  // field extraction, every cycle
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd, shamt;
  logic [15:0] imm16;
  logic [25:0] addr26;
  logic [31:0] imm_sx;

  assign instr  = imem[pc_q[IAW+1:2]];
  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign shamt  = instr[10:6];
  assign funct  = instr[5:0];
  assign imm16  = instr[15:0];
  assign addr26 = instr[25:0];
  assign imm_sx = {{16{imm16[15]}}, imm16};

  // control
  logic    reg_write, reg_dst, alu_src, mem_to_reg, mem_write, branch, jump;
  alu_op_t alu_op;

  always_comb begin
    reg_write  = 1'b0;
    reg_dst    = 1'b0;
    alu_src    = 1'b0;
    mem_to_reg = 1'b0;
    mem_write  = 1'b0;
    branch     = 1'b0;
    jump       = 1'b0;
    alu_op     = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        reg_dst = 1'b1;
        case (funct)
          FN_ADD: begin reg_write = 1'b1; alu_op = ALU_ADD; end
          FN_SUB: begin reg_write = 1'b1; alu_op = ALU_SUB; end
          FN_AND: begin reg_write = 1'b1; alu_op = ALU_AND; end
          FN_OR:  begin reg_write = 1'b1; alu_op = ALU_OR;  end
          FN_SLT: begin reg_write = 1'b1; alu_op = ALU_SLT; end
          default: reg_write = 1'b0;
        endcase
      end
      OP_ADDI: begin
        reg_write = 1'b1;
        alu_src   = 1'b1;
      end
      OP_LW: begin
        reg_write  = 1'b1;
        alu_src    = 1'b1;
        mem_to_reg = 1'b1;
      end
      OP_SW: begin
        alu_src   = 1'b1;
        mem_write = 1'b1;
      end
      OP_BEQ: begin
        branch = 1'b1;
        alu_op = ALU_SUB;
      end
      OP_J: jump = 1'b1;
      default: ;
    endcase
  end

  // register read, combinational, register 0 forced to zero
  logic [31:0] rs_val, rt_val;
  assign rs_val = (rs == 5'd0) ? 32'd0 : regs[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : regs[rt];

  // execute
  logic [31:0] alu_b, alu_res;
  logic        alu_zero;
  assign alu_b = alu_src ? imm_sx : rt_val;

  always_comb begin
    case (alu_op)
      ALU_SUB: alu_res = rs_val - alu_b;
      ALU_AND: alu_res = rs_val & alu_b;
      ALU_OR:  alu_res = rs_val | alu_b;
      ALU_SLT: alu_res = {31'd0, $signed(rs_val) < $signed(alu_b)};
      default: alu_res = rs_val + alu_b;
    endcase
  end
  assign alu_zero = (alu_res == 32'd0);

  // memory access
  logic [31:0] mem_rdata;
  assign mem_rdata = dmem[alu_res[DAW+1:2]];

  // write-back
  logic [4:0]  dst;
  logic [31:0] wdata;
  logic        commit;
  assign dst    = reg_dst ? rd : rt;
  assign wdata  = mem_to_reg ? mem_rdata : alu_res;
  assign commit = rst_n & reg_write & (dst != 5'd0);

  // next pc
  logic [31:0] pc_plus4, br_target, j_target, pc_next;
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_sx[29:0], 2'b00};
  assign j_target  = {pc_plus4[31:28], addr26, 2'b00};

  always_comb begin
    if (jump)                  pc_next = j_target;
    else if (branch && alu_zero) pc_next = br_target;
    else                       pc_next = pc_plus4;
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= 32'd0;
      for (int i = 0; i < NREGS; i++) regs[i] <= 32'd0;
    end else begin
      pc_q <= pc_next;
      if (commit) regs[dst] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_we && !ld_dmem) imem[ld_addr[IAW+1:2]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_we && ld_dmem)       dmem[ld_addr[DAW+1:2]] <= ld_data;
    else if (rst_n && mem_write) dmem[alu_res[DAW+1:2]] <= rt_val;
  end

  // observation
  assign pc      = pc_q;
  assign wb_en   = commit;
  assign wb_addr = dst;
  assign wb_data = wdata;
  assign st_en   = rst_n & mem_write;
  assign st_addr = alu_res;
  assign st_data = rt_val;

  logic unused_fields;
  assign unused_fields = ^{shamt, ld_addr[31:2+(IAW > DAW ? IAW : DAW)], ld_addr[1:0]};
endmodule

// File: rtl/scp_core_sva.sv
module scp_core_sva (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        wb_en,
  input logic [4:0]  wb_addr,
  input logic        st_en
);
  logic [5:0]  op;
  logic [31:0] nxt, bt, jt;
  assign op  = instr[31:26];
  assign nxt = pc + 32'd4;
  assign bt  = nxt + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jt  = {nxt[31:28], instr[25:0], 2'b00};

  p_pc_reset_r1: assert property (@(posedge clk) !rst_n |=> pc == 32'd0);

  p_zero_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_addr != 5'd0);

  p_store_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> !wb_en);

  p_beq_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op == 6'h04 |=> (pc == $past(nxt) || pc == $past(bt)));

  p_jump_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op == 6'h02 |=> pc == $past(jt));

  p_seq_pc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 6'h04 && op != 6'h02) |=> pc == $past(nxt));

  p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);
endmodule

bind scp_core scp_core_sva u_scp_core_sva (
  .clk(clk), .rst_n(rst_n), .pc(pc), .instr(instr),
  .wb_en(wb_en), .wb_addr(wb_addr), .st_en(st_en)
);

// File: tb/test_scp_core.sv
module test_scp_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0, ld_dmem = 1'b0;
  logic [31:0] ld_addr = '0, ld_data = '0;
  logic [31:0] pc, instr, wb_data, st_addr, st_data;
  logic        wb_en, st_en;
  logic [4:0]  wb_addr;

  scp_core i_scp_core (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc(pc), .instr(instr),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .st_en(st_en), .st_addr(st_addr), .st_data(st_data)
  );

  always #2 clk = ~clk;

  int  n_checks = 0, n_fail = 0;
  bit  done = 1'b0;

  logic [31:0] m_reg [32];
  logic [31:0] m_imem [64];
  logic [31:0] m_dmem [64];
  logic [31:0] m_pc;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [4:0] s, input logic [4:0] t,
                                        input logic [4:0] d, input logic [5:0] fn);
    return {6'h00, s, t, d, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] s,
                                        input logic [4:0] t, input logic [15:0] imm);
    return {op, s, t, imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [31:0] target);
    return {6'h02, target[27:2]};
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    case (w[31:26])
      6'h00: case (w[5:0])
               6'h20: return "R2";
               6'h22, 6'h24, 6'h25, 6'h2A: return "R3";
               default: return "R11";
             endcase
      6'h08: return "R4";
      6'h23: return "R6";
      6'h2B: return "R7";
      6'h04: return "R8";
      6'h02: return "R9";
      default: return "R11";
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    string pc_tag = "R1";
    for (int i = 0; i < 64; i++) begin
      m_imem[i] = 32'h0000_0000;
      m_dmem[i] = 32'hA500_0000 | i;
    end
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    m_imem[0]  = enc_i(6'h08, 0, 1, 16'd5);
    m_imem[1]  = enc_i(6'h08, 0, 2, 16'd10);
    m_imem[2]  = enc_r(1, 2, 3, 6'h20);
    m_imem[3]  = enc_r(1, 2, 4, 6'h22);
    m_imem[4]  = enc_r(1, 2, 5, 6'h24);
    m_imem[5]  = enc_r(1, 2, 6, 6'h25);
    m_imem[6]  = enc_r(4, 1, 7, 6'h2A);
    m_imem[7]  = enc_r(1, 4, 8, 6'h2A);
    m_imem[8]  = enc_i(6'h08, 0, 9, 16'hFFFC);
    m_imem[9]  = enc_i(6'h08, 1, 0, 16'd7);
    m_imem[10] = enc_r(0, 0, 10, 6'h20);
    m_imem[11] = enc_i(6'h2B, 0, 6, 16'h0011);
    m_imem[12] = enc_i(6'h23, 0, 11, 16'h0010);
    m_imem[13] = enc_i(6'h23, 9, 12, 16'h0023);
    m_imem[14] = enc_i(6'h04, 1, 2, 16'd5);
    m_imem[15] = enc_i(6'h04, 3, 6, 16'd2);
    m_imem[16] = enc_i(6'h08, 0, 13, 16'd1);
    m_imem[17] = enc_i(6'h08, 0, 13, 16'd2);
    m_imem[18] = 32'hFC00_0000;
    m_imem[19] = enc_r(20, 21, 16, 6'h20);
    m_imem[20] = enc_r(1, 2, 3, 6'h27);
    m_imem[21] = enc_j(32'h60);
    m_imem[22] = enc_i(6'h08, 15, 15, 16'd1);
    m_imem[23] = enc_i(6'h2B, 0, 15, 16'd8);
    m_imem[24] = enc_i(6'h04, 0, 0, 16'hFFFD);

    check(enc_r(1, 2, 3, 6'h20) == 32'h0022_1820, "R2", "add encoding",
          enc_r(1, 2, 3, 6'h20), 32'h0022_1820);

    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_dmem = 1'b0; ld_addr = i * 4; ld_data = m_imem[i];
    end
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_dmem = 1'b1; ld_addr = i * 4; ld_data = m_dmem[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
    #1;
    check(pc == 32'd0, "R1", "pc in reset", pc, 32'd0);
    check(wb_en == 1'b0, "R1", "wb_en in reset", {31'd0, wb_en}, 32'd0);
    check(st_en == 1'b0, "R1", "st_en in reset", {31'd0, st_en}, 32'd0);
    m_pc = 32'd0;

    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 60; cyc++) begin
      logic [31:0] w, a, b, sx, res, nxt;
      logic [4:0]  d;
      logic        we, se;
      string       tg;
      #1;
      w  = m_imem[m_pc[7:2]];
      tg = tag_of(w);
      a  = m_reg[w[25:21]];
      b  = m_reg[w[20:16]];
      sx = {{16{w[15]}}, w[15:0]};
      we = 1'b0; se = 1'b0; d = w[20:16]; res = 32'd0;
      nxt = m_pc + 4;
      case (w[31:26])
        6'h00: begin
          d = w[15:11];
          we = 1'b1;
          case (w[5:0])
            6'h20: res = a + b;
            6'h22: res = a - b;
            6'h24: res = a & b;
            6'h25: res = a | b;
            6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: we = 1'b0;
          endcase
        end
        6'h08: begin we = 1'b1; res = a + sx; end
        6'h23: begin we = 1'b1; res = m_dmem[((a + sx) >> 2) % 64]; end
        6'h2B: se = 1'b1;
        6'h04: if (a == b) nxt = m_pc + 4 + (sx << 2);
        6'h02: nxt = {m_pc[31:28] + ((m_pc + 4) >> 28) - m_pc[31:28], w[25:0], 2'b00};
        default: ;
      endcase
      if (we && d == 5'd0) begin
        we = 1'b0;
        tg = "R5";
      end

      check(pc == m_pc, pc_tag, "pc", pc, m_pc);
      check(instr == w, pc_tag, "fetched word", instr, w);
      check(wb_en == we, tg, "wb_en", {31'd0, wb_en}, {31'd0, we});
      if (we) begin
        check(wb_addr == d, tg, "wb_addr", {27'd0, wb_addr}, {27'd0, d});
        check(wb_data == res, tg, "wb_data", wb_data, res);
      end
      check(st_en == se, tg, "st_en", {31'd0, st_en}, {31'd0, se});
      if (se) begin
        check(st_addr == a + sx, "R7", "st_addr", st_addr, a + sx);
        check(st_data == b, "R7", "st_data", st_data, b);
      end
      if (cyc == 2) check(wb_en && wb_addr == 5'd3 && wb_data == 32'd15,
                          "R12", "third result", wb_data, 32'd15);
      if (cyc == 3) check(pc == 32'h0000_000C, "R12", "pc after three", pc, 32'h0C);

      if (we) m_reg[d] = res;
      if (se) m_dmem[((a + sx) >> 2) % 64] = b;
      pc_tag = (w[31:26] == 6'h04 || w[31:26] == 6'h02) ? tag_of(w) : "R10";
      m_pc = nxt;
      @(negedge clk);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule